// File: doc/BRIEF.md
# Two-Digit Sum Display Decoder

This block turns the five-bit result of adding two decimal digits into something a person can read on two display positions. The input is the carry-out of a four-bit adder placed above four sum bits, so it holds a binary value that can legally run from 0 to 18. The block drives seven active-high segment lines for the units digit, one line for the tens position (which can only be 0 or 1), and an error line for codes that two decimal digits can never produce.

The decoder is purely combinational. It has no clock, no reset and no handshake. The outputs follow the inputs within the same evaluation. Data arrives as a plain level-valued bus, and no back-pressure applies. A companion ripple adder module, with its carry-in tied low, is provided to produce the input from two four-bit addends. Its sum bus connects bit for bit, least significant to least significant.

Top module: `sum_display_decoder`

## Requirements
- R1: The input value is `{sum_carry, sum_bits[3:0]}`, with the carry as bit 4 (weight 16) and `sum_bits[0]` as bit 0.
- R2: For input values 10 through 18, `tens_on` is 1. For values 0 through 9 it is 0.
- R3: For input values 0 through 18, `seg_units` shows the digit equal to the value modulo 10.
- R4: Segment encoding is active high, with bit 6 = a, 5 = b, 4 = c, 3 = d, 2 = e, 1 = f and 0 = g. The digits 0..9 are 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F, 7B (hex).
- R5: `range_err` is 1 exactly when the input value is 19 or larger (19..31). Otherwise it is 0.
- R6: While `range_err` is 1, `seg_units` is 0x01 (segment g only, a dash) and `tens_on` is 0.
- R7: The companion adder outputs `{carry_out, sum}` equal to the 5-bit sum of two 4-bit addends, with a carry-in of 0.
- R8: The outputs depend only on the present inputs. A change of input shows at the outputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sum_carry | input | 1 | Carry-out of the digit adder, bit 4 of the value |
| sum_bits | input | 4 | Low four sum bits of the value |
| seg_units | output | 7 | Units digit segments, bit 6 = a down to bit 0 = g, active high |
| tens_on | output | 1 | Tens digit (0 or 1) |
| range_err | output | 1 | Value above 18 |

## Verification
There is no stored state, so any wrong internal decision appears at the ports in the same evaluation as the input that exposes it. A wrong range compare shows up first at the boundary codes 18 and 19, as a missing error flag or a stray tens bit. A wrong subtraction in the units path shows up as the wrong pattern for 10 through 18. A bit-order fault between the adder and the decoder only shows when particular addend pairs are applied, so the bench sweeps every pair of decimal addends through the adder.

// File: rtl/sumdisp_pkg.sv
package sumdisp_pkg;
  localparam int DIGIT_W   = 4;
  localparam int VAL_W     = DIGIT_W + 1;
  localparam int SEG_W     = 7;
  localparam int RADIX     = 10;
  localparam int MAX_LEGAL = 2 * (RADIX - 1);

  localparam logic [SEG_W-1:0] SEG_DASH = 7'b000_0001;

  // bit 6 = a ... bit 0 = g, active high
  function automatic logic [SEG_W-1:0] seg_of_digit(input logic [DIGIT_W-1:0] d);
    logic [SEG_W-1:0] p;
    case (d)
      4'd0:    p = 7'b111_1110;
      4'd1:    p = 7'b011_0000;
      4'd2:    p = 7'b110_1101;
      4'd3:    p = 7'b111_1001;
      4'd4:    p = 7'b011_0011;
      4'd5:    p = 7'b101_1011;
      4'd6:    p = 7'b101_1111;
      4'd7:    p = 7'b111_0000;
      4'd8:    p = 7'b111_1111;
      4'd9:    p = 7'b111_1011;
      default: p = SEG_DASH;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/digit_adder.sv
module digit_adder #(
  parameter int W = sumdisp_pkg::DIGIT_W
) (
  input  logic [W-1:0] add_a,
  input  logic [W-1:0] add_b,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;  // carry-in tied low

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]     = add_a[i] ^ add_b[i] ^ chain[i];
    assign chain[i+1] = (add_a[i] & add_b[i]) | (chain[i] & (add_a[i] ^ add_b[i]));
  end

  assign carry_out = chain[W];

  always_comb begin
    assert_sum_exact_R7: assert ({carry_out, sum} == ({1'b0, add_a} + {1'b0, add_b}))
      else $error("R7 adder result mismatch");
  end
endmodule

// File: rtl/sum_splitter.sv
module sum_splitter
  import sumdisp_pkg::*;
(
  input  logic [VAL_W-1:0]   value,
  output logic [DIGIT_W-1:0] units,
  output logic               tens,
  output logic               over
);
  logic [VAL_W-1:0] less_radix;

  assign over       = (value > VAL_W'(MAX_LEGAL));
  assign tens       = !over && (value >= VAL_W'(RADIX));
  assign less_radix = value - VAL_W'(RADIX);
  assign units      = tens ? less_radix[DIGIT_W-1:0] : value[DIGIT_W-1:0];

  always_comb begin
    assert_units_below_radix_R3: assert (over || (units < DIGIT_W'(RADIX)))
      else $error("R3 units digit out of range");
    assert_value_recombines_R2: assert (over || ({1'b0, units} + (tens ? VAL_W'(RADIX) : '0)) == value)
      else $error("R2 tens/units split wrong");
  end
endmodule

// File: rtl/seg_encoder.sv
module seg_encoder
  import sumdisp_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  input  logic               blank_err,
  output logic [SEG_W-1:0]   segs
);
  assign segs = blank_err ? SEG_DASH : seg_of_digit(digit);

  always_comb begin
    assert_dash_single_seg_R6: assert (!blank_err || ($countones(segs) == 1 && segs[0]))
      else $error("R6 error pattern not a dash");
  end
endmodule

// File: rtl/sum_display_decoder.sv
module sum_display_decoder
  import sumdisp_pkg::*;
(
  input  logic               sum_carry,
  input  logic [DIGIT_W-1:0] sum_bits,
  output logic [SEG_W-1:0]   seg_units,
  output logic               tens_on,
  output logic               range_err
);
  logic [VAL_W-1:0]   value;
  logic [DIGIT_W-1:0] units_digit;

  assign value = {sum_carry, sum_bits};

  sum_splitter u_split (
    .value (value),
    .units (units_digit),
    .tens  (tens_on),
    .over  (range_err)
  );

  seg_encoder u_enc (
    .digit     (units_digit),
    .blank_err (range_err),
    .segs      (seg_units)
  );

  always_comb begin
    assert_no_tens_in_error_R6: assert (!(range_err && tens_on))
      else $error("R6 tens shown during error");
    assert_carry_high_is_tens_or_err_R5: assert (!sum_carry || tens_on || range_err)
      else $error("R5 value >= 16 neither tens nor error");
  end
endmodule

// File: tb/sum_display_decoder_tb.sv
module sum_display_decoder_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int errors = 0;

  logic       use_adder = 1'b0;
  logic       d_carry = 1'b0;
  logic [3:0] d_bits = 4'd0;
  logic [3:0] ta = 4'd0, tb = 4'd0;
  logic [3:0] a_sum;
  logic       a_cout;
  logic [6:0] seg;
  logic       tens, err;

  digit_adder u_add (.add_a(ta), .add_b(tb), .sum(a_sum), .carry_out(a_cout));

  sum_display_decoder u_dut (
    .sum_carry (use_adder ? a_cout : d_carry),
    .sum_bits  (use_adder ? a_sum  : d_bits),
    .seg_units (seg),
    .tens_on   (tens),
    .range_err (err)
  );

  localparam logic [6:0] DIG [0:9] = '{7'h7E, 7'h30, 7'h6D, 7'h79, 7'h33,
                                      7'h5B, 7'h5F, 7'h70, 7'h7F, 7'h7B};

  // {value, tens, seg}
  localparam logic [12:0] VEC [0:18] = '{
    {5'd0, 1'b0, 7'h7E}, {5'd1, 1'b0, 7'h30}, {5'd2, 1'b0, 7'h6D},
    {5'd3, 1'b0, 7'h79}, {5'd4, 1'b0, 7'h33}, {5'd5, 1'b0, 7'h5B},
    {5'd6, 1'b0, 7'h5F}, {5'd7, 1'b0, 7'h70}, {5'd8, 1'b0, 7'h7F},
    {5'd9, 1'b0, 7'h7B}, {5'd10, 1'b1, 7'h7E}, {5'd11, 1'b1, 7'h30},
    {5'd12, 1'b1, 7'h6D}, {5'd13, 1'b1, 7'h79}, {5'd14, 1'b1, 7'h33},
    {5'd15, 1'b1, 7'h5B}, {5'd16, 1'b1, 7'h5F}, {5'd17, 1'b1, 7'h70},
    {5'd18, 1'b1, 7'h7F}};

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got err/tens/seg=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input int v);
    if (v > 18) return {1'b1, 1'b0, 7'h01};
    return {1'b0, (v >= 10), DIG[v % 10]};
  endfunction

  task automatic apply_code(input int v);
    @(negedge clk);
    use_adder = 1'b0;
    {d_carry, d_bits} = 5'(v);
    #1;
  endtask

  logic done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // initial state: input zero shows digit 0
    apply_code(0);
    chk("R3 initial", {err, tens, seg}, {1'b0, 1'b0, 7'h7E});

    // R1 R2 R3 R4: table walk over legal codes
    for (int i = 0; i < 19; i++) begin
      apply_code(int'(VEC[i][12:8]));
      chk("R2/R3/R4 table", {err, tens, seg}, {1'b0, VEC[i][7], VEC[i][6:0]});
    end

    // R5 R6: every illegal code
    for (int v = 19; v < 32; v++) begin
      apply_code(v);
      chk("R5/R6 illegal", {err, tens, seg}, {1'b1, 1'b0, 7'h01});
    end

    // R5 boundary 18 -> 19
    apply_code(18);
    chk("R5 boundary 18", {err, tens, seg}, model(18));
    apply_code(19);
    chk("R5 boundary 19", {err, tens, seg}, model(19));

    // R1: carry alone is weight 16
    apply_code(16);
    chk("R1 carry weight", {err, tens, seg}, {1'b0, 1'b1, 7'h5F});

    // R7: every BCD addend pair through the adder
    for (int a = 0; a < 10; a++) begin
      for (int b = 0; b < 10; b++) begin
        @(negedge clk);
        use_adder = 1'b1; ta = 4'(a); tb = 4'(b);
        #1;
        chk("R7 adder pair", {err, tens, seg}, model(a + b));
      end
    end

    // R7: non-BCD addends flagged
    @(negedge clk);
    use_adder = 1'b1; ta = 4'd15; tb = 4'd15;
    #1;
    chk("R7 15+15", {err, tens, seg}, model(30));

    // R8: change with no clock edge in between
    @(posedge clk);
    #0.5;
    use_adder = 1'b0; {d_carry, d_bits} = 5'd7;
    #0.5;
    chk("R8 immediate 7", {err, tens, seg}, model(7));
    {d_carry, d_bits} = 5'd25;
    #0.5;
    chk("R8 immediate 25", {err, tens, seg}, model(25));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule